// File: doc/BRIEF.md
# Oscillator-clocked watchdog with reset and interrupt-pulse modes

This block is a watchdog timer for a chip's system-control area. An up-counter advances on a divided oscillator clock and must be cleared from time to time by software, which writes a two-value key sequence. If software fails to clear it, the counter wraps. What happens then depends on the run-time mode. In reset mode the block raises a chip reset request for a fixed number of cycles and sets a sticky cause flag. In interrupt mode it pulls an active-low interrupt line low for a fixed number of oscillator cycles. The falling edge of that line is what the downstream interrupt or wake logic reacts to.

A control register sets the enable, the mode and the prescale. It also holds a check field that must always be written with a fixed pattern. Writes to it are accepted only while a protected-access enable input is high. A status output repeats the level of the interrupt line, so software can see whether a pulse is still under way before it changes the mode.

The pulse timer and the counter only run while the watchdog is enabled, so disabling it in the middle of a pulse freezes the line low. Changing from interrupt mode to reset mode while the line is low fires the reset at once.

Top module: `wdg_top`

## Requirements
- R1: After the synchronous reset, irq_n and irq_lvl are 1, wd_rst and wd_caused are 0, and the watchdog is enabled in reset mode with prescale select 0.
- R2: Control byte layout: bit 0 disables when 1; bit 1 selects interrupt mode when 1 and reset mode when 0; bits 4:2 hold the prescale select s; bits 7:5 are the check field. The counter advances once every BASE_DIV*2^min(s,6) enabled cycles. After a key clear at edge E, the first overflow takes effect at edge E + 2^CNT_W * BASE_DIV * 2^min(s,6).
- R3: In interrupt mode an overflow drives irq_n low for exactly PULSE_LEN enabled cycles, after which it returns high.
- R4: irq_lvl always equals the level of irq_n.
- R5: In reset mode an overflow drives wd_rst high for exactly RST_LEN cycles starting after the overflow edge, and sets wd_caused, which stays 1 until the synchronous reset.
- R6: A key write of 0x55 followed directly by a key write of 0xAA clears the counter and prescaler. Any other key value disarms the sequence, and 0xAA without a preceding 0x55 has no effect.
- R7: While disabled, the counter holds its value and cannot overflow. Counting resumes from the held value when the watchdog is enabled again.
- R8: Disabling the watchdog during an interrupt pulse freezes the pulse timer and keeps irq_n low. After re-enabling, the remaining part of the pulse completes.
- R9: Disabling the watchdog while irq_n is high leaves irq_n high and wd_rst low.
- R10: A valid control write that changes the mode from interrupt to reset while irq_n is low makes wd_rst high and releases irq_n in the cycle right after the write edge.
- R11: A control write while prot_en is 0 has no effect, including one with a wrong check field.
- R12: A protected control write whose check field is not 101 leaves the configuration unchanged and performs the overflow action of the current mode immediately.
- R13: An overflow or fault in interrupt mode never asserts wd_rst and never sets wd_caused.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous active-high reset |
| prot_en | input | 1 | Protected-access enable; gates control writes |
| ctrl_we | input | 1 | Control register write strobe |
| ctrl_wdata | input | 8 | Control write data |
| key_we | input | 1 | Key register write strobe |
| key_wdata | input | 8 | Key write data |
| irq_n | output | 1 | Active-low interrupt pulse |
| irq_lvl | output | 1 | Status: current level of irq_n |
| wd_rst | output | 1 | Chip reset request |
| wd_caused | output | 1 | Sticky flag: the watchdog requested a reset |

## Verification
The overflow point is swept across all eight prescale codes in interrupt mode. The level is sampled one cycle before and at the predicted edge, which separates an off-by-one in the base divider, the prescale decode or the saturation of codes above 6. Key sequences are tried broken, unarmed and valid; only the valid one may move the overflow edge. Disables are placed before a pulse, inside one and after one, and the predicted resume and release edges separate a timer that freezes from one that keeps running or restarts. Faulty, unprotected and mode-switching control writes are compared on irq_n, wd_rst and the cause flag, which tells apart a fault that acts in the wrong mode, a gate that leaks, and a switch that waits instead of firing at once.

// File: rtl/wdg_pkg.sv
package wdg_pkg;

    localparam int               SEL_W        = 3;
    localparam int               SUB_W        = 6;
    localparam logic [SEL_W-1:0] SEL_TOP      = 3'd6;
    localparam logic [2:0]       CHECK_PATTERN = 3'b101;
    localparam logic [7:0]       KEY_ARM      = 8'h55;
    localparam logic [7:0]       KEY_FIRE     = 8'hAA;

    typedef enum logic {
        MODE_RESET = 1'b0,
        MODE_IRQ   = 1'b1
    } wd_mode_e;

    typedef struct packed {
        logic [2:0]       check;
        logic [SEL_W-1:0] sel;
        wd_mode_e         mode;
        logic             dis;
    } wd_ctrl_t;

    localparam wd_ctrl_t CTRL_RESET_VAL = '{
        check: CHECK_PATTERN,
        sel:   '0,
        mode:  MODE_RESET,
        dis:   1'b0
    };

    // select codes above the top divider behave like the top divider
    function automatic logic [SEL_W-1:0] clamp_sel(input logic [SEL_W-1:0] s);
        return (s > SEL_TOP) ? SEL_TOP : s;
    endfunction

    // mask of prescaler bits that must all be one to emit a tick
    function automatic logic [SUB_W-1:0] sub_mask(input logic [SEL_W-1:0] s);
        logic [SUB_W:0] one_hot;
        one_hot = (SUB_W+1)'(1) << clamp_sel(s);
        return SUB_W'(one_hot - (SUB_W+1)'(1));
    endfunction

endpackage

// File: rtl/wdg_prescaler.sv
module wdg_prescaler
    import wdg_pkg::*;
#(
    parameter int BASE_DIV = 512
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             clr,
    input  logic [SEL_W-1:0] sel,
    output logic             tick
);

    logic             base_tick;
    logic [SUB_W-1:0] sub_q;
    logic [SUB_W-1:0] mask;
    logic             sub_full;

    generate
        if (BASE_DIV <= 1) begin : g_no_base
            assign base_tick = run;
        end else begin : g_base
            localparam int BW = $clog2(BASE_DIV);
            localparam logic [BW-1:0] BASE_LAST = BW'(BASE_DIV - 1);
            logic [BW-1:0] base_q;

            assign base_tick = run && (base_q == BASE_LAST);

            always_ff @(posedge clk) begin
                if (rst || clr) begin
                    base_q <= '0;
                end else if (run) begin
                    base_q <= base_tick ? '0 : base_q + 1'b1;
                end
            end
        end
    endgenerate

    assign mask     = sub_mask(sel);
    assign sub_full = ((sub_q & mask) == mask);
    assign tick     = base_tick && sub_full;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            sub_q <= '0;
        end else if (base_tick) begin
            sub_q <= sub_full ? '0 : sub_q + 1'b1;
        end
    end

endmodule

// File: rtl/wdg_key.sv
module wdg_key
    import wdg_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       key_we,
    input  logic [7:0] key_wdata,
    output logic       clear
);

    logic armed_q;

    assign clear = key_we && armed_q && (key_wdata == KEY_FIRE);

    always_ff @(posedge clk) begin
        if (rst) begin
            armed_q <= 1'b0;
        end else if (key_we) begin
            armed_q <= (key_wdata == KEY_ARM);
        end
    end

endmodule

// File: rtl/wdg_pulse.sv
module wdg_pulse
    import wdg_pkg::*;
#(
    parameter int PULSE_LEN = 512,
    parameter int RST_LEN   = 512
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     run,
    input  logic     trip,
    input  wd_mode_e mode,
    input  logic     force_rst,
    output logic     irq_n,
    output logic     wd_rst,
    output logic     wd_caused
);

    localparam int PW = $clog2(PULSE_LEN + 1);
    localparam int RW = $clog2(RST_LEN + 1);
    localparam logic [PW-1:0] PULSE_LOAD = PW'(PULSE_LEN);
    localparam logic [RW-1:0] RST_LOAD   = RW'(RST_LEN);

    logic [PW-1:0] pls_q;
    logic [RW-1:0] rcnt_q;
    logic          caused_q;
    logic          rst_evt;
    logic          irq_start;

    assign irq_start = trip && (mode == MODE_IRQ) && (pls_q == '0);
    assign rst_evt   = force_rst || (trip && (mode == MODE_RESET));

    always_ff @(posedge clk) begin
        if (rst || force_rst) begin
            pls_q <= '0;
        end else if (irq_start) begin
            pls_q <= PULSE_LOAD;
        end else if (run && pls_q != '0) begin
            pls_q <= pls_q - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rcnt_q   <= '0;
            caused_q <= 1'b0;
        end else if (rst_evt) begin
            rcnt_q   <= RST_LOAD;
            caused_q <= 1'b1;
        end else if (rcnt_q != '0) begin
            rcnt_q <= rcnt_q - 1'b1;
        end
    end

    assign irq_n     = (pls_q == '0);
    assign wd_rst    = (rcnt_q != '0);
    assign wd_caused = caused_q;

endmodule

// File: rtl/wdg_top.sv
module wdg_top
    import wdg_pkg::*;
#(
    parameter int CNT_W     = 8,
    parameter int BASE_DIV  = 512,
    parameter int PULSE_LEN = 512,
    parameter int RST_LEN   = 512
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       prot_en,
    input  logic       ctrl_we,
    input  logic [7:0] ctrl_wdata,
    input  logic       key_we,
    input  logic [7:0] key_wdata,
    output logic       irq_n,
    output logic       irq_lvl,
    output logic       wd_rst,
    output logic       wd_caused
);

    wd_ctrl_t         cfg_q;
    wd_ctrl_t         cfg_in;
    logic             cfg_acc;
    logic             cfg_ok;
    logic             cfg_bad;
    logic             wd_en;
    logic             key_clr;
    logic             tick;
    logic [CNT_W-1:0] cnt_q;
    logic             cnt_wrap;
    logic             trip;
    logic             force_rst;

    assign cfg_in  = wd_ctrl_t'(ctrl_wdata);
    assign cfg_acc = ctrl_we && prot_en;
    assign cfg_ok  = cfg_acc && (cfg_in.check == CHECK_PATTERN);
    assign cfg_bad = cfg_acc && (cfg_in.check != CHECK_PATTERN);
    assign wd_en   = !cfg_q.dis;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= CTRL_RESET_VAL;
        end else if (cfg_ok) begin
            cfg_q <= cfg_in;
        end
    end

    wdg_key u_key (
        .clk       (clk),
        .rst       (rst),
        .key_we    (key_we),
        .key_wdata (key_wdata),
        .clear     (key_clr)
    );

    wdg_prescaler #(
        .BASE_DIV (BASE_DIV)
    ) u_presc (
        .clk  (clk),
        .rst  (rst),
        .run  (wd_en),
        .clr  (key_clr),
        .sel  (cfg_q.sel),
        .tick (tick)
    );

    assign cnt_wrap = tick && (cnt_q == '1);

    always_ff @(posedge clk) begin
        if (rst || key_clr) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign trip      = cnt_wrap || cfg_bad;
    assign force_rst = cfg_ok && (cfg_q.mode == MODE_IRQ)
                       && (cfg_in.mode == MODE_RESET) && !irq_n;

    wdg_pulse #(
        .PULSE_LEN (PULSE_LEN),
        .RST_LEN   (RST_LEN)
    ) u_pulse (
        .clk       (clk),
        .rst       (rst),
        .run       (wd_en),
        .trip      (trip),
        .mode      (cfg_q.mode),
        .force_rst (force_rst),
        .irq_n     (irq_n),
        .wd_rst    (wd_rst),
        .wd_caused (wd_caused)
    );

    assign irq_lvl = irq_n;

endmodule

// File: rtl/wdg_checker.sv
module wdg_checker #(
    parameter int CNT_W     = 8,
    parameter int PULSE_LEN = 512
) (
    input logic             clk,
    input logic             rst,
    input logic             prot_en,
    input logic             ctrl_we,
    input logic [7:0]       ctrl_wdata,
    input logic             key_we,
    input logic             irq_n,
    input logic             wd_rst,
    input logic             wd_caused,
    input logic             wd_en,
    input logic [CNT_W-1:0] cnt_q,
    input logic [7:0]       cfg_q
);

    int unsigned low_run;

    always_ff @(posedge clk) begin
        if (rst || irq_n) begin
            low_run <= 0;
        end else if (wd_en) begin
            low_run <= low_run + 1;
        end
    end

    // R3
    pulse_len_chk: assert property (@(posedge clk) disable iff (rst)
        low_run <= PULSE_LEN);

    // R5
    cause_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        wd_rst |-> wd_caused);

    // R13
    irq_no_rst_chk: assert property (@(posedge clk) disable iff (rst)
        !irq_n |-> !$rose(wd_rst));

    // R8
    hold_low_chk: assert property (@(posedge clk) disable iff (rst)
        (!wd_en && !irq_n && !ctrl_we) |=> !irq_n);

    // R11
    write_gate_chk: assert property (@(posedge clk) disable iff (rst)
        (ctrl_we && !prot_en) |=> $stable(cfg_q));

    // R7
    freeze_chk: assert property (@(posedge clk) disable iff (rst)
        (!wd_en && !key_we) |=> $stable(cnt_q));

    // R10
    mode_swap_chk: assert property (@(posedge clk) disable iff (rst)
        (ctrl_we && prot_en && ctrl_wdata[7:5] == 3'b101 && !ctrl_wdata[1]
         && cfg_q[1] && !irq_n) |=> (wd_rst && irq_n));

endmodule

bind wdg_top wdg_checker #(
    .CNT_W     (CNT_W),
    .PULSE_LEN (PULSE_LEN)
) u_wdg_chk (
    .clk        (clk),
    .rst        (rst),
    .prot_en    (prot_en),
    .ctrl_we    (ctrl_we),
    .ctrl_wdata (ctrl_wdata),
    .key_we     (key_we),
    .irq_n      (irq_n),
    .wd_rst     (wd_rst),
    .wd_caused  (wd_caused),
    .wd_en      (wd_en),
    .cnt_q      (cnt_q),
    .cfg_q      (cfg_q)
);

// File: tb/test_wdg_top.sv
`timescale 1ns/1ps
module test_wdg_top;

    localparam int CNT_W     = 3;
    localparam int BASE_DIV  = 4;
    localparam int PULSE_LEN = 8;
    localparam int RST_LEN   = 4;
    localparam int N2        = (1 << CNT_W) * BASE_DIV * 4;  // select 2
    localparam int WD_LIMIT  = 100000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       prot_en = 1'b0;
    logic       ctrl_we = 1'b0;
    logic [7:0] ctrl_wdata = 8'h00;
    logic       key_we = 1'b0;
    logic [7:0] key_wdata = 8'h00;
    logic       irq_n;
    logic       irq_lvl;
    logic       wd_rst;
    logic       wd_caused;

    int cyc = 0;
    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    wdg_top #(
        .CNT_W     (CNT_W),
        .BASE_DIV  (BASE_DIV),
        .PULSE_LEN (PULSE_LEN),
        .RST_LEN   (RST_LEN)
    ) i_wdg_top (
        .clk        (clk),
        .rst        (rst),
        .prot_en    (prot_en),
        .ctrl_we    (ctrl_we),
        .ctrl_wdata (ctrl_wdata),
        .key_we     (key_we),
        .key_wdata  (key_wdata),
        .irq_n      (irq_n),
        .irq_lvl    (irq_lvl),
        .wd_rst     (wd_rst),
        .wd_caused  (wd_caused)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s at cycle %0d: actual %0d expected %0d", req, cyc, act, exp);
        end
    endtask

    function automatic logic [7:0] mk(input int sel, input bit irq_mode, input bit dis);
        return {3'b101, 3'(sel), irq_mode, dis};
    endfunction

    task automatic write_ctrl(input logic [7:0] v, input bit prot);
        ctrl_we = 1'b1; ctrl_wdata = v; prot_en = prot;
        @(negedge clk);
        ctrl_we = 1'b0; prot_en = 1'b0;
    endtask

    task automatic write_key(input logic [7:0] v);
        key_we = 1'b1; key_wdata = v;
        @(negedge clk);
        key_we = 1'b0;
    endtask

    task automatic service();
        write_key(8'h55);
        write_key(8'hAA);
    endtask

    task automatic wait_to(input int t);
        while (cyc < t) @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (WD_LIMIT) @(posedge clk);
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog expired at cycle %0d: actual 0 expected 1", cyc);
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin : stim
        int t0, t1, t2, tb, to, td, te, ts, n, rem;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(irq_n == 1'b1 && irq_lvl == 1'b1, "R1 irq idle", irq_n, 1);
        chk(wd_rst == 1'b0 && wd_caused == 1'b0, "R1 reset idle", wd_rst, 0);

        // R2 R3 R4 R13 sweep over every prescale code in interrupt mode
        for (int s = 0; s < 8; s++) begin
            write_ctrl(mk(s, 1'b1, 1'b0), 1'b1);
            service();
            t0 = cyc;
            n = (1 << CNT_W) * BASE_DIV * (1 << ((s > 6) ? 6 : s));
            wait_to(t0 + n - 1);
            chk(irq_n == 1'b1, "R2 no overflow yet", irq_n, 1);
            wait_to(t0 + n);
            chk(irq_n == 1'b0, "R2 overflow edge", irq_n, 0);
            chk(irq_lvl == irq_n, "R4 status low", irq_lvl, irq_n);
            chk(wd_rst == 1'b0 && wd_caused == 1'b0, "R13 no reset in irq mode", wd_rst, 0);
            wait_to(t0 + n + PULSE_LEN - 1);
            chk(irq_n == 1'b0, "R3 pulse still low", irq_n, 0);
            wait_to(t0 + n + PULSE_LEN);
            chk(irq_n == 1'b1, "R3 pulse released", irq_n, 1);
            chk(irq_lvl == irq_n, "R4 status high", irq_lvl, irq_n);
        end

        // R6 broken and unarmed key sequences do not clear
        write_ctrl(mk(2, 1'b1, 1'b0), 1'b1);
        service();
        t0 = cyc;
        wait_to(t0 + 20);
        write_key(8'h55);
        write_key(8'h12);
        write_key(8'hAA);
        wait_to(t0 + N2 - 1);
        chk(irq_n == 1'b1, "R6 broken seq before edge", irq_n, 1);
        wait_to(t0 + N2);
        chk(irq_n == 1'b0, "R6 broken seq did not clear", irq_n, 0);
        wait_to(t0 + N2 + PULSE_LEN + 2);
        write_key(8'hAA);
        wait_to(t0 + 2 * N2);
        chk(irq_n == 1'b0, "R6 unarmed AA did not clear", irq_n, 0);
        wait_to(t0 + 2 * N2 + PULSE_LEN + 1);
        service();
        t1 = cyc;
        wait_to(t1 + N2 - 1);
        chk(irq_n == 1'b1, "R6 valid seq moved edge", irq_n, 1);
        wait_to(t1 + N2);
        chk(irq_n == 1'b0, "R6 valid seq edge", irq_n, 0);
        wait_to(t1 + N2 + PULSE_LEN + 1);

        // R7 disabled counter holds and resumes
        service();
        t0 = cyc;
        wait_to(t0 + 30);
        write_ctrl(mk(2, 1'b1, 1'b1), 1'b1);
        t1 = cyc;
        wait_to(t1 + 300);
        chk(irq_n == 1'b1, "R7 no overflow while disabled", irq_n, 1);
        write_ctrl(mk(2, 1'b1, 1'b0), 1'b1);
        t2 = cyc;
        to = t2 + N2 - (t1 - t0);
        wait_to(to - 1);
        chk(irq_n == 1'b1, "R7 resume before edge", irq_n, 1);
        wait_to(to);
        chk(irq_n == 1'b0, "R7 resume edge", irq_n, 0);

        // R8 disable during pulse freezes it
        wait_to(to + 3);
        write_ctrl(mk(2, 1'b1, 1'b1), 1'b1);
        td = cyc;
        wait_to(td + 60);
        chk(irq_n == 1'b0 && irq_lvl == 1'b0, "R8 held low while disabled", irq_n, 0);
        write_ctrl(mk(2, 1'b1, 1'b0), 1'b1);
        te = cyc;
        rem = PULSE_LEN - (td - to);
        wait_to(te + rem - 1);
        chk(irq_n == 1'b0, "R8 remaining pulse", irq_n, 0);
        wait_to(te + rem);
        chk(irq_n == 1'b1, "R8 release after resume", irq_n, 1);

        // R9 disable after pulse
        write_ctrl(mk(2, 1'b1, 1'b1), 1'b1);
        wait_to(cyc + 40);
        chk(irq_n == 1'b1 && wd_rst == 1'b0, "R9 idle after late disable", irq_n, 1);
        write_ctrl(mk(2, 1'b1, 1'b0), 1'b1);

        // R11 unprotected writes ignored
        service();
        t0 = cyc;
        write_ctrl(8'h00, 1'b0);
        chk(irq_n == 1'b1, "R11 bad check w/o access no fault", irq_n, 1);
        write_ctrl(mk(2, 1'b1, 1'b1), 1'b0);
        wait_to(t0 + N2 - 1);
        chk(irq_n == 1'b1, "R11 before edge", irq_n, 1);
        wait_to(t0 + N2);
        chk(irq_n == 1'b0, "R11 still enabled", irq_n, 0);
        wait_to(t0 + N2 + PULSE_LEN + 1);

        // R12 fault in interrupt mode
        service();
        write_ctrl(8'h00, 1'b1);
        tb = cyc;
        chk(irq_n == 1'b0 && wd_rst == 1'b0, "R12 fault gives irq", irq_n, 0);
        wait_to(tb + PULSE_LEN - 1);
        chk(irq_n == 1'b0, "R12 config kept, pulse runs", irq_n, 0);
        wait_to(tb + PULSE_LEN);
        chk(irq_n == 1'b1, "R12 pulse end", irq_n, 1);
        chk(wd_caused == 1'b0, "R13 flag clear after irq faults", wd_caused, 0);

        // R5 reset mode overflow
        write_ctrl(mk(2, 1'b0, 1'b0), 1'b1);
        service();
        t0 = cyc;
        wait_to(t0 + N2 - 1);
        chk(wd_rst == 1'b0 && wd_caused == 1'b0, "R5 before edge", wd_rst, 0);
        wait_to(t0 + N2);
        chk(wd_rst == 1'b1 && wd_caused == 1'b1 && irq_n == 1'b1, "R5 reset edge", wd_rst, 1);
        wait_to(t0 + N2 + RST_LEN - 1);
        chk(wd_rst == 1'b1, "R5 reset length", wd_rst, 1);
        wait_to(t0 + N2 + RST_LEN);
        chk(wd_rst == 1'b0 && wd_caused == 1'b1, "R5 release, flag sticky", wd_rst, 0);

        // R12 fault in reset mode
        service();
        write_ctrl(8'h00, 1'b1);
        chk(wd_rst == 1'b1 && irq_n == 1'b1, "R12 fault gives reset", wd_rst, 1);
        wait_to(cyc + RST_LEN + 1);

        // R10 switch to reset mode during pulse
        write_ctrl(mk(2, 1'b1, 1'b0), 1'b1);
        service();
        t0 = cyc;
        wait_to(t0 + N2 + 2);
        chk(irq_n == 1'b0, "R10 pulse active", irq_n, 0);
        write_ctrl(mk(2, 1'b0, 1'b0), 1'b1);
        ts = cyc;
        chk(wd_rst == 1'b1 && irq_n == 1'b1, "R10 immediate reset", wd_rst, 1);
        wait_to(ts + RST_LEN - 1);
        chk(wd_rst == 1'b1, "R10 reset length", wd_rst, 1);
        wait_to(ts + RST_LEN);
        chk(wd_rst == 1'b0, "R10 reset release", wd_rst, 0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule